// File: doc/BRIEF.md
# Adaptive Midpoint Sync Slicer

This block recovers a clean composite sync bit from a stream of digitized composite video samples that have already been clamped and low-pass filtered. A sample-rate enable marks the clock cycles that carry a new sample. A coarse comparator, set a fixed offset above the clamp level, finds the leading and trailing edges of every sync pulse. Those edges start two timed gates. One gate samples the sync tip a short time after the leading edge. The other samples the back porch just after the trailing edge.

Each gate feeds a first-order smoothing register. The final comparator slices every sample at the midpoint of the two tracked levels, with a hysteresis band around that midpoint. Until the first complete measurement exists, the output follows the coarse comparator. When the input is lost, the tracked levels stay where they were, so the sync output remains asserted for as long as the input stays at the clamp level. Gate lengths are given in tenths of a microsecond and converted to sample counts from a clocks-per-microsecond parameter, so the block scales with the scan rate.

Top module: `sync_slicer`

## Requirements
- R1: `slice_level` always equals floor((`tip_level` + `porch_level`)/2). For a settled input with a stable tip and porch, it lies between 40% and 60% of the way from the input tip value to the input porch value.
- R2: A sample below the coarse threshold (CLAMP_LEVEL + COARSE_OFS, 160 by default) counts as sync. While `level_valid` is 0, `csync_n` is the registered inverse of that comparison.
- R3: The tip gate takes its first sample 5 samples after the leading-edge sample (4 samples of delay by default), then takes up to 10 samples. `tip_level` changes only on samples taken by that gate.
- R4: A trailing edge closes an open tip gate at once. The trailing-edge sample and every later sample of that pulse are kept out of `tip_level`.
- R5: The porch gate is started by the trailing edge. It skips the trailing-edge sample and the next 2 samples, then takes 10 samples. `porch_level` changes only on those samples, and a leading edge closes the gate.
- R6: After a step change of input levels, three full lines bring each tracked level to within amplitude/16 + 8 codes of the new input value.
- R7: Once `level_valid` is 1, `csync_n` falls only on a sample below `slice_level` − HYST and rises only on a sample above `slice_level` + HYST (HYST = 8). Samples inside the band leave it unchanged.
- R8: When the input stays at the clamp level, `porch_level` keeps its value and `csync_n` stays 0 for the whole outage.
- R9: `csync_n` is active low. It changes only on the clock edge that takes a sample and reflects that sample. After settling, each line holds it low for exactly as many samples as the sync pulse is long.
- R10: After reset, `csync_n` = 1, `level_valid` = 0, `tip_level` = 64 (CLAMP_LEVEL) and `porch_level` = 256 (CLAMP_LEVEL + 2·COARSE_OFS).
- R11: `level_valid` is set when a porch gate completes after at least one tip sample has been taken. It stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | High on cycles that carry a new sample |
| sample | input | SAMPLE_W | Clamped, filtered video sample, sync tip lowest |
| csync_n | output | 1 | Composite sync, low during sync |
| slice_level | output | SAMPLE_W | Current midpoint threshold |
| tip_level | output | SAMPLE_W | Tracked sync-tip level |
| porch_level | output | SAMPLE_W | Tracked back-porch level |
| level_valid | output | 1 | A full tip/porch measurement exists |

## Verification
The assertions assume that the input keeps the sync tip below the coarse threshold and the porch above it. They also assume that each sync pulse is longer than the tip delay, so that the tracked porch lies above the tracked tip. The stimulus uses step edges with every tip value at or below 150 and every porch value at or above 200. Even the deliberately disturbed gate-placement lines stay on the correct side of both the coarse threshold and the hysteresis band. Samples arrive every other clock, so the assertions that hold the output between enables are exercised on every line.

// File: rtl/sync_slicer_pkg.sv
package sync_slicer_pkg;

  typedef enum logic [1:0] {
    GT_IDLE = 2'd0,
    GT_WAIT = 2'd1,
    GT_OPEN = 2'd2
  } gate_state_e;

  // Converts a duration in tenths of a microsecond into a rounded sample count.
  function automatic int unsigned tenths_to_samples(int unsigned cyc_per_us, int unsigned tenths);
    return (cyc_per_us * tenths + 5) / 10;
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
  parameter int unsigned W   = 10,
  parameter int unsigned THR = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [W-1:0] sample,
  output logic         below,
  output logic         lead,
  output logic         trail
);
  logic coarse_q;

  assign below = (sample < W'(THR));
  assign lead  = sample_en &  below & ~coarse_q;
  assign trail = sample_en & ~below &  coarse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         coarse_q <= 1'b0;
    else if (sample_en) coarse_q <= below;
  end

  // R2
  lead_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coarse_q) |-> $past(lead));
  // R2
  trail_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(coarse_q) |-> $past(trail));
endmodule

// File: rtl/sync_gate_timer.sv
module sync_gate_timer
  import sync_slicer_pkg::*;
#(
  parameter int unsigned DLY = 4,
  parameter int unsigned LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic start,
  input  logic abort,
  output logic gate,
  output logic take,
  output logic done
);
  localparam int unsigned MAXC = (DLY > LEN) ? DLY : LEN;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'((DLY == 0) ? 0 : DLY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(LEN - 1);

  gate_state_e   state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GT_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      if (DLY == 0) begin
        state_q <= GT_OPEN;
        cnt_q   <= LEN_LAST;
      end else begin
        state_q <= GT_WAIT;
        cnt_q   <= DLY_LAST;
      end
    end else if (abort) begin
      state_q <= GT_IDLE;
      cnt_q   <= '0;
    end else if (sample_en) begin
      case (state_q)
        GT_WAIT: begin
          if (cnt_q == '0) begin
            state_q <= GT_OPEN;
            cnt_q   <= LEN_LAST;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        GT_OPEN: begin
          if (cnt_q == '0) state_q <= GT_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= GT_IDLE;
      endcase
    end
  end

  assign gate = (state_q == GT_OPEN);
  assign take = sample_en & gate & ~abort & ~start;
  assign done = take & (cnt_q == '0);

  // checker state: samples taken in the current open window
  logic [CW:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_q <= '0;
    else if (!gate) run_q <= '0;
    else if (take)  run_q <= run_q + 1'b1;
  end

  // R3
  open_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (CW+1)'(LEN));
  // R4
  abort_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !gate);
  // R3
  open_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(state_q) == GT_WAIT || DLY == 0));
endmodule

// File: rtl/sync_level_track.sv
module sync_level_track #(
  parameter int unsigned W     = 10,
  parameter int unsigned K     = 3,
  parameter int unsigned INIT  = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] sample,
  output logic [W-1:0] level
);
  // One first-order smoothing step: moves by (sample - current) >>> K.
  function automatic logic [W-1:0] iir_next(logic [W-1:0] cur, logic [W-1:0] smp);
    logic signed [W+1:0] diff;
    logic signed [W+1:0] step;
    logic signed [W+1:0] nxt;
    diff = $signed({2'b00, smp}) - $signed({2'b00, cur});
    step = diff >>> K;
    nxt  = $signed({2'b00, cur}) + step;
    return nxt[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    level <= W'(INIT);
    else if (take) level <= iir_next(level, sample);
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(level));
  // R6
  toward_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sample >= level) |=> (level >= $past(level) && level <= $past(sample)));
  // R6
  toward_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sample < level) |=> (level < $past(level) && level >= $past(sample)));
endmodule

// File: rtl/sync_slicer.sv
module sync_slicer
  import sync_slicer_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 10,
  parameter int unsigned CYC_PER_US  = 5,
  parameter int unsigned CLAMP_LEVEL = 64,
  parameter int unsigned COARSE_OFS  = 96,
  parameter int unsigned HYST        = 8,
  parameter int unsigned TRACK_SHIFT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                csync_n,
  output logic [SAMPLE_W-1:0] slice_level,
  output logic [SAMPLE_W-1:0] tip_level,
  output logic [SAMPLE_W-1:0] porch_level,
  output logic                level_valid
);
  localparam int unsigned COARSE_THR = CLAMP_LEVEL + COARSE_OFS;
  localparam int unsigned TIP_DLY    = tenths_to_samples(CYC_PER_US, 8);
  localparam int unsigned TIP_LEN    = tenths_to_samples(CYC_PER_US, 20);
  localparam int unsigned PORCH_SKIP = tenths_to_samples(CYC_PER_US, 4);
  localparam int unsigned PORCH_LEN  = tenths_to_samples(CYC_PER_US, 20);
  localparam int unsigned TIP_INIT   = CLAMP_LEVEL;
  localparam int unsigned PORCH_INIT = CLAMP_LEVEL + 2 * COARSE_OFS;
  localparam logic [SAMPLE_W:0] MAXV = (SAMPLE_W+1)'((1 << SAMPLE_W) - 1);

  function automatic logic [SAMPLE_W-1:0] midpoint(logic [SAMPLE_W-1:0] a, logic [SAMPLE_W-1:0] b);
    logic [SAMPLE_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[SAMPLE_W:1];
  endfunction

  function automatic logic [SAMPLE_W-1:0] band_low(logic [SAMPLE_W-1:0] m);
    return (m > SAMPLE_W'(HYST)) ? m - SAMPLE_W'(HYST) : '0;
  endfunction

  function automatic logic [SAMPLE_W-1:0] band_high(logic [SAMPLE_W-1:0] m);
    logic [SAMPLE_W:0] s;
    s = {1'b0, m} + (SAMPLE_W+1)'(HYST);
    return (s > MAXV) ? MAXV[SAMPLE_W-1:0] : s[SAMPLE_W-1:0];
  endfunction

  // named internal events
  logic coarse_below, sync_lead, sync_trail;
  logic tip_gate, tip_take, tip_done;
  logic porch_gate, porch_take, porch_done;
  logic tip_seen_q, valid_q, sync_q;
  logic [SAMPLE_W-1:0] thr_lo, thr_hi;

  sync_edge_det #(.W(SAMPLE_W), .THR(COARSE_THR)) u_edge (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample(sample),
    .below(coarse_below), .lead(sync_lead), .trail(sync_trail)
  );

  sync_gate_timer #(.DLY(TIP_DLY), .LEN(TIP_LEN)) u_tip_gate (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .start(sync_lead), .abort(sync_trail),
    .gate(tip_gate), .take(tip_take), .done(tip_done)
  );

  sync_gate_timer #(.DLY(PORCH_SKIP), .LEN(PORCH_LEN)) u_porch_gate (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .start(sync_trail), .abort(sync_lead),
    .gate(porch_gate), .take(porch_take), .done(porch_done)
  );

  sync_level_track #(.W(SAMPLE_W), .K(TRACK_SHIFT), .INIT(TIP_INIT)) u_tip_lvl (
    .clk(clk), .rst_n(rst_n), .take(tip_take), .sample(sample), .level(tip_level)
  );

  sync_level_track #(.W(SAMPLE_W), .K(TRACK_SHIFT), .INIT(PORCH_INIT)) u_porch_lvl (
    .clk(clk), .rst_n(rst_n), .take(porch_take), .sample(sample), .level(porch_level)
  );

  assign slice_level = midpoint(tip_level, porch_level);
  assign thr_lo      = band_low(slice_level);
  assign thr_hi      = band_high(slice_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tip_seen_q <= 1'b0;
      valid_q    <= 1'b0;
    end else begin
      if (tip_take)               tip_seen_q <= 1'b1;
      if (porch_done && tip_seen_q) valid_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
    end else if (sample_en) begin
      if (!valid_q)                        sync_q <= coarse_below;
      else if (!sync_q && sample < thr_lo) sync_q <= 1'b1;
      else if ( sync_q && sample > thr_hi) sync_q <= 1'b0;
    end
  end

  assign csync_n     = ~sync_q;
  assign level_valid = valid_q;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(csync_n));
  // R11
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_valid |=> level_valid);
  // R7
  band_keep_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && level_valid && csync_n && sample >= thr_lo) |=> csync_n);
  // R7
  band_keep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && level_valid && !csync_n && sample <= thr_hi) |=> !csync_n);
  // R1
  slice_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (porch_level >= tip_level) |-> (slice_level >= tip_level && slice_level <= porch_level));
  // R3
  gates_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tip_take && porch_take));
endmodule

// File: tb/test_sync_slicer.sv
module test_sync_slicer;
  localparam int W = 10;
  localparam int HYST = 8;
  localparam int NV = 4;
  localparam int LINE = 64;
  // stimulus / expected table: tip, porch, sync length, expected low samples per line
  localparam int V_TIP  [NV] = '{64, 64, 120, 64};
  localparam int V_PORCH[NV] = '{300, 600, 900, 200};
  localparam int V_SYNC [NV] = '{24, 20, 28, 24};
  localparam int V_LOWS [NV] = '{24, 20, 28, 24};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic [W-1:0] sample = '0;
  logic csync_n, level_valid;
  logic [W-1:0] slice_level, tip_level, porch_level;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sync_slicer i_sync_slicer (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample(sample),
    .csync_n(csync_n), .slice_level(slice_level), .tip_level(tip_level),
    .porch_level(porch_level), .level_valid(level_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_sample(input int v);
    @(negedge clk);
    sample = W'(v);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  function automatic int absd(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // mode 0: plain line; mode 1: disturbed values outside the gate windows
  task automatic run_line(input int mode, input int tip, input int porch, input int slen, output int lows);
    lows = 0;
    for (int i = 0; i < LINE; i++) begin
      int v;
      int vid;
      vid = (porch + 150 > 1023) ? 1023 : porch + 150;
      if (mode == 0) begin
        if (i < slen)           v = tip;
        else if (i < slen + 20) v = porch;
        else                    v = vid;
      end else begin
        if (i < 5)       v = 150;
        else if (i < 15) v = tip;
        else if (i < 24) v = 150;
        else if (i < 27) v = 200;
        else if (i < 37) v = porch;
        else if (i < 44) v = 200;
        else             v = vid;
      end
      drive_sample(v);
      if (csync_n == 1'b0) lows++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lows;
    int mid;
    int highs;
    int held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(csync_n == 1'b1, "R10 csync_n", csync_n, 1);
    check(level_valid == 1'b0, "R10 level_valid", level_valid, 0);
    check(tip_level == 64, "R10 tip_level", tip_level, 64);
    check(porch_level == 256, "R10 porch_level", porch_level, 256);
    rst_n = 1'b1;
    // R2 coarse path before a measurement exists
    drive_sample(100);
    check(csync_n == 1'b0, "R2 coarse low", csync_n, 0);
    check(level_valid == 1'b0, "R11 not yet valid", level_valid, 0);
    drive_sample(300);
    check(csync_n == 1'b1, "R2 coarse high", csync_n, 1);

    for (int k = 0; k < NV; k++) begin
      int amp;
      int tol;
      int lo40;
      int hi60;
      for (int l = 0; l < 3; l++) run_line(0, V_TIP[k], V_PORCH[k], V_SYNC[k], lows);
      amp = V_PORCH[k] - V_TIP[k];
      tol = amp / 16 + 8;
      check(lows == V_LOWS[k], "R9 low samples per line", lows, V_LOWS[k]);
      check(absd(tip_level, V_TIP[k]) <= tol, "R6 tip settle", tip_level, V_TIP[k]);
      check(absd(porch_level, V_PORCH[k]) <= tol, "R6 porch settle", porch_level, V_PORCH[k]);
      check(slice_level == (tip_level + porch_level) / 2, "R1 midpoint", slice_level,
            (tip_level + porch_level) / 2);
      lo40 = V_TIP[k] + (amp * 4) / 10;
      hi60 = V_TIP[k] + (amp * 6) / 10;
      check(slice_level >= lo40 && slice_level <= hi60, "R1 40-60 window", slice_level, (lo40 + hi60) / 2);
      if (k == 0) check(level_valid == 1'b1, "R11 valid after first line", level_valid, 1);
    end

    // R8 loss of signal
    held = porch_level;
    highs = 0;
    for (int i = 0; i < 2000; i++) begin
      drive_sample(64);
      if (csync_n == 1'b1) highs++;
    end
    check(highs == 0, "R8 sync held low", highs, 0);
    check(porch_level == held, "R8 porch held", porch_level, held);
    check(level_valid == 1'b1, "R11 valid sticky", level_valid, 1);

    for (int l = 0; l < 3; l++) run_line(0, 64, 300, 24, lows);
    // R7 hysteresis band
    mid = slice_level;
    for (int i = 0; i < 3; i++) drive_sample(mid - HYST + 2);
    check(csync_n == 1'b1, "R7 inside band stays high", csync_n, 1);
    drive_sample(mid - HYST - 3);
    check(csync_n == 1'b0, "R7 below band goes low", csync_n, 0);
    for (int i = 0; i < 3; i++) drive_sample(mid + HYST - 2);
    check(csync_n == 1'b0, "R7 inside band stays low", csync_n, 0);
    drive_sample(mid + HYST + 3);
    check(csync_n == 1'b1, "R7 above band goes high", csync_n, 1);

    // R3 and R5 gate placement: disturbed values only outside the windows
    for (int l = 0; l < 3; l++) run_line(1, 64, 300, 24, lows);
    check(tip_level >= 64 && tip_level < 80, "R3 tip window placement", tip_level, 64);
    check(porch_level >= 290 && porch_level <= 300, "R5 porch window placement", porch_level, 300);
    check(lows == 24, "R9 low samples disturbed line", lows, 24);

    // R4 short sync: trailing edge must close the tip window
    for (int l = 0; l < 3; l++) run_line(0, 64, 300, 8, lows);
    check(tip_level >= 64 && tip_level < 80, "R4 short sync tip", tip_level, 64);
    check(lows == 8, "R9 low samples short sync", lows, 8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule